// File: doc/BRIEF.md
# Configuration Request Packet Builder

This block converts one configuration-space access into a request packet for a root port's transmit path. A request names a target bus, a device/function, a byte address, an access size (1, 2 or 4 bytes), a direction and, for writes, a data word. The block builds a three-dword header and an optional data dword. It sends them as 64-bit beats, each marked with start-of-packet and end-of-packet flags.

The block keeps its own copy of the root bus number. It uses that copy to choose between type 0 encoding (the target sits on the root bus) and type 1 encoding (all other buses). It also uses the copy to screen out accesses that must never reach the link. A rejected request produces a one-cycle error pulse and no beats. A write that reprograms the root port's primary bus number register updates the stored copy once the packet has been fully handed off.

Both the request side and the beat side use valid/ready handshakes. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no packet is pending, so one packet is in flight at most. A beat moves on a cycle where `beat_valid` and `beat_ready` are both high. While `beat_ready` is low, the presented beat and its flags are held unchanged. The consumer may hold `beat_ready` low for any number of cycles.

Top module: `cfgb_builder`

## Requirements
- R1: `req_ready` is high exactly when no packet is pending. An accepted, non-rejected request presents its first beat in the following cycle. A beat that is not accepted keeps its data and flags stable until it is accepted.
- R2: Header dword 0 carries a format/type byte in bits 31:24 and the value 1 in bits 9:0. The byte is 0x04 for a read and 0x44 for a write when the target bus equals the stored root bus number. It is 0x05 for a read and 0x45 for a write otherwise.
- R3: Header dword 1 is made of three fields. Bits 31:24 hold the stored root bus number, and bits 23:16 hold zero. Bits 15:8 hold tag 0x1D for a read or 0x10 for a write. Bits 3:0 hold the byte enables, and bits 7:4 are zero.
- R4: Let lane be addr[1:0]. Size code 0 (1 byte) gives byte enables 0b0001 shifted left by lane. Size code 1 (2 bytes) gives 0b0011 shifted left by lane, truncated to 4 bits. Size codes 2 and 3 (4 bytes) give 0xF.
- R5: Header dword 2 holds the bus in bits 31:24 and the device/function in bits 23:16. Bits 11:0 hold the address with its two low bits cleared, and bits 15:12 are zero.
- R6: Write data is first masked to its low 8 bits (size 0), its low 16 bits (size 1) or all 32 bits (sizes 2 and 3). It is then shifted left by 8 × lane and truncated to 32 bits.
- R7: Reads, and writes with addr[2] = 1, take two beats. Beat one is {dword1, dword0} with only the start flag. Beat two is {data or zero for a read, dword2} with only the end flag.
- R8: Writes with addr[2] = 0 take three beats. Beat one is as in R7. Beat two is {0, dword2} with no flags. Beat three is {0, data} with only the end flag.
- R9: A request to device/function 0 on the stored root bus is rejected when its address, low two bits ignored, equals 0x10.
- R10: A request whose device number (devfn[7:3]) is non-zero is rejected when it targets the stored root bus or the root bus plus one (modulo 256). A rejected request drives `rej_pulse` high for exactly the cycle after acceptance and produces no beat.
- R11: The stored root bus number is 0 after reset. After the final beat of a write is accepted, the stored number becomes bits 7:0 of the write's shifted data. This applies only to a non-rejected write on the stored root bus whose address, low two bits ignored, equals 0x18. Later requests use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (no packet pending) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device (7:3) and function (2:0) |
| req_addr | input | 12 | Byte address in configuration space |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata | input | 32 | Write value, right-aligned |
| beat_valid | output | 1 | Beat presented |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_data | output | 64 | Beat payload, low dword first in the packet order |
| beat_sop | output | 1 | First beat of a packet |
| beat_eop | output | 1 | Last beat of a packet |
| rej_pulse | output | 1 | One-cycle pulse: the accepted request was rejected |

## Verification
Random requests mix three kinds of target bus: the stored root bus, the bus just below it, and arbitrary buses. Comparing the header format byte and the rejection outcomes across these tells type 0 from type 1 encoding, and tells the two rejection scopes apart. Addresses alternate between random values, the hidden base register and the primary bus register. Together with all four size codes, they separate the two-beat and three-beat layouts, exercise the byte-enable and data-shift tables at every lane, and repeatedly move the stored root bus so that later requests must follow the new value. Random back-pressure on `beat_ready` shows whether held beats stay unchanged, and directed cases pin down reset, each rejection rule and a root bus change.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int BUS_W  = 8;
  localparam int DF_W   = 8;
  localparam int ADDR_W = 12;
  localparam int DW     = 32;
  localparam int BEAT_W = 2 * DW;
  localparam int BE_W   = DW / 8;
  localparam int OFS_PAD = 16 - ADDR_W;

  localparam logic [7:0] FMT_RD_LOCAL  = 8'h04;
  localparam logic [7:0] FMT_WR_LOCAL  = 8'h44;
  localparam logic [7:0] FMT_RD_REMOTE = 8'h05;
  localparam logic [7:0] FMT_WR_REMOTE = 8'h45;
  localparam logic [7:0] TAG_READ      = 8'h1D;
  localparam logic [7:0] TAG_WRITE     = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_HIDDEN_BAR = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_PRIMARY    = 12'h018;

  typedef struct packed {
    logic [DW-1:0] dw0;
    logic [DW-1:0] dw1;
    logic [DW-1:0] dw2;
    logic [DW-1:0] data;
    logic          three;
    logic          root_hit;
  } pkt_t;
endpackage

// File: rtl/cfgb_encode.sv
module cfgb_encode
  import cfgb_pkg::*;
(
  input  logic              write,
  input  logic [BUS_W-1:0]  bus,
  input  logic [DF_W-1:0]   devfn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [DW-1:0]     wdata,
  input  logic [BUS_W-1:0]  root,
  output pkt_t              pkt
);
  logic              remote;
  logic [7:0]        fmt;
  logic [7:0]        tag;
  logic [1:0]        lane;
  logic [BE_W-1:0]   be;
  logic [DW-1:0]     mask;
  logic [DW-1:0]     placed;
  logic [ADDR_W-1:0] ofs;

  always_comb begin
    remote = (bus != root);
    lane   = addr[1:0];
    ofs    = {addr[ADDR_W-1:2], 2'b00};
    tag    = write ? TAG_WRITE : TAG_READ;
    unique case ({write, remote})
      2'b00:   fmt = FMT_RD_LOCAL;
      2'b01:   fmt = FMT_RD_REMOTE;
      2'b10:   fmt = FMT_WR_LOCAL;
      default: fmt = FMT_WR_REMOTE;
    endcase
    unique case (size)
      2'd0: begin be = BE_W'(4'b0001) << lane; mask = DW'(32'h0000_00FF); end
      2'd1: begin be = BE_W'(4'b0011) << lane; mask = DW'(32'h0000_FFFF); end
      default: begin be = '1; mask = '1; end
    endcase
    placed = (wdata & mask) << {lane, 3'b000};

    pkt.dw0      = {fmt, 24'd1};
    pkt.dw1      = {root, 8'h00, tag, 4'h0, be};
    pkt.dw2      = {bus, devfn, {OFS_PAD{1'b0}}, ofs};
    pkt.data     = write ? placed : '0;
    pkt.three    = write && !addr[2];
    pkt.root_hit = write && !remote && (ofs == OFS_PRIMARY);
  end
endmodule

// File: rtl/cfgb_screen.sv
module cfgb_screen
  import cfgb_pkg::*;
(
  input  logic [BUS_W-1:0]  bus,
  input  logic [DF_W-1:0]   devfn,
  input  logic [ADDR_W-3:0] dw_addr,
  input  logic [BUS_W-1:0]  root,
  output logic              reject
);
  logic [BUS_W-1:0] below;
  logic             on_root;
  logic             dev_nz;
  logic             hidden;

  always_comb begin
    below   = root + BUS_W'(1);
    on_root = (bus == root);
    dev_nz  = |devfn[DF_W-1:3];
    hidden  = on_root && (devfn == '0) && (dw_addr == OFS_HIDDEN_BAR[ADDR_W-1:2]);
    reject  = hidden || ((on_root || (bus == below)) && dev_nz);
  end
endmodule

// File: rtl/cfgb_beat_seq.sv
module cfgb_beat_seq
  import cfgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  pkt_t              pkt_in,
  input  logic              beat_ready,
  output logic              busy,
  output logic              beat_valid,
  output logic [BEAT_W-1:0] beat_data,
  output logic              beat_sop,
  output logic              beat_eop,
  output logic              done,
  output logic              done_root_hit,
  output logic [BUS_W-1:0]  done_root_val
);
  pkt_t       pkt_q;
  logic       active;
  logic [1:0] idx;
  logic       last;

  assign last = pkt_q.three ? (idx == 2'd2) : (idx == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      pkt_q  <= '0;
    end else if (load) begin
      active <= 1'b1;
      idx    <= '0;
      pkt_q  <= pkt_in;
    end else if (active && beat_ready) begin
      if (last) active <= 1'b0;
      else      idx    <= idx + 2'd1;
    end
  end

  always_comb begin
    beat_sop = 1'b0;
    beat_eop = 1'b0;
    unique case (idx)
      2'd0: begin
        beat_data = {pkt_q.dw1, pkt_q.dw0};
        beat_sop  = 1'b1;
      end
      2'd1: begin
        beat_data = pkt_q.three ? {{DW{1'b0}}, pkt_q.dw2} : {pkt_q.data, pkt_q.dw2};
        beat_eop  = !pkt_q.three;
      end
      default: begin
        beat_data = {{DW{1'b0}}, pkt_q.data};
        beat_eop  = 1'b1;
      end
    endcase
  end

  assign busy          = active;
  assign beat_valid    = active;
  assign done          = active && beat_ready && last;
  assign done_root_hit = pkt_q.root_hit;
  assign done_root_val = pkt_q.data[BUS_W-1:0];
endmodule

// File: rtl/cfgb_builder.sv
module cfgb_builder
  import cfgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DF_W-1:0]   req_devfn,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DW-1:0]     req_wdata,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [BEAT_W-1:0] beat_data,
  output logic              beat_sop,
  output logic              beat_eop,
  output logic              rej_pulse
);
  logic [BUS_W-1:0] root_q;
  logic             busy;
  logic             accept;
  logic             reject;
  logic             done;
  logic             done_root_hit;
  logic [BUS_W-1:0] done_root_val;
  pkt_t             pkt;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  cfgb_screen u_screen (
    .bus     (req_bus),
    .devfn   (req_devfn),
    .dw_addr (req_addr[ADDR_W-1:2]),
    .root    (root_q),
    .reject  (reject)
  );

  cfgb_encode u_encode (
    .write (req_write),
    .bus   (req_bus),
    .devfn (req_devfn),
    .addr  (req_addr),
    .size  (req_size),
    .wdata (req_wdata),
    .root  (root_q),
    .pkt   (pkt)
  );

  cfgb_beat_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (accept && !reject),
    .pkt_in        (pkt),
    .beat_ready    (beat_ready),
    .busy          (busy),
    .beat_valid    (beat_valid),
    .beat_data     (beat_data),
    .beat_sop      (beat_sop),
    .beat_eop      (beat_eop),
    .done          (done),
    .done_root_hit (done_root_hit),
    .done_root_val (done_root_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_q    <= '0;
      rej_pulse <= 1'b0;
    end else begin
      rej_pulse <= accept && reject;
      if (done && done_root_hit) root_q <= done_root_val;
    end
  end
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker
  import cfgb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [BEAT_W-1:0] beat_data,
  input logic              beat_sop,
  input logic              beat_eop,
  input logic              rej_pulse
);
  assert_first_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ((beat_valid && beat_sop) || rej_pulse));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_data)
                                     && $stable(beat_sop) && $stable(beat_eop)));

  assert_length_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_sop) |-> (beat_data[9:0] == 10'd1));

  assert_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_sop) |-> (beat_data[47:40] == TAG_READ || beat_data[47:40] == TAG_WRITE));

  assert_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> $onehot0({beat_sop, beat_eop}));

  assert_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_eop) |=> !beat_valid);

  assert_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_sop) |=> (beat_valid && !beat_sop));

  assert_reject_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |-> !beat_valid);
endmodule

bind cfgb_builder cfgb_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_data  (beat_data),
  .beat_sop   (beat_sop),
  .beat_eop   (beat_eop),
  .rej_pulse  (rej_pulse)
);

// File: tb/cfgb_builder_test.sv
`timescale 1ns/1ps
module cfgb_builder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [7:0]  req_devfn = '0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [63:0] beat_data;
  logic        beat_sop;
  logic        beat_eop;
  logic        rej_pulse;

  int   checks = 0;
  int   errors = 0;
  logic [7:0] m_root = 8'h00;

  always #2.5 clk = ~clk;

  cfgb_builder uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
    .beat_sop(beat_sop), .beat_eop(beat_eop), .rej_pulse(rej_pulse)
  );

  task automatic chk(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] lane);
    logic [3:0] b;
    case (sz)
      2'd0: b = 4'b0001 << lane;
      2'd1: b = 4'b0011 << lane;
      default: b = 4'hF;
    endcase
    return b;
  endfunction

  function automatic logic [31:0] exp_data(input logic [1:0] sz, input logic [1:0] lane, input logic [31:0] v);
    logic [31:0] m;
    case (sz)
      2'd0: m = 32'h0000_00FF;
      2'd1: m = 32'h0000_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return (v & m) << (8 * lane);
  endfunction

  function automatic bit exp_reject(input logic [7:0] bus, input logic [7:0] devfn, input logic [11:0] addr);
    bit on_root = (bus == m_root);
    bit below   = (bus == 8'(m_root + 8'd1));
    bit hidden  = on_root && devfn == 8'h00 && addr[11:2] == 10'h004;
    return hidden || ((on_root || below) && devfn[7:3] != 5'd0);
  endfunction

  task automatic run_req(input bit wr, input logic [7:0] bus, input logic [7:0] devfn,
                         input logic [11:0] addr, input logic [1:0] sz,
                         input logic [31:0] wd, input int bp);
    bit          rej = exp_reject(bus, devfn, addr);
    bit          remote = (bus != m_root);
    logic [7:0]  fmt;
    logic [31:0] d0, d1, d2, dd;
    logic [11:0] ofs = {addr[11:2], 2'b00};
    logic [65:0] exp [3];
    int          n;
    int          idx;
    int          guard;
    fmt = wr ? (remote ? 8'h45 : 8'h44) : (remote ? 8'h05 : 8'h04);
    dd  = wr ? exp_data(sz, addr[1:0], wd) : 32'h0;
    d0  = {fmt, 24'd1};
    d1  = {m_root, 8'h00, (wr ? 8'h10 : 8'h1D), 4'h0, exp_be(sz, addr[1:0])};
    d2  = {bus, devfn, 4'h0, ofs};
    exp[0] = {2'b10, d1, d0};
    if (wr && !addr[2]) begin
      n = 3;
      exp[1] = {2'b00, 32'h0, d2};
      exp[2] = {2'b01, 32'h0, dd};
    end else begin
      n = 2;
      exp[1] = {2'b01, dd, d2};
      exp[2] = '0;
    end

    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready when idle", 66'(req_ready), 66'(1));
    req_valid = 1'b1; req_write = wr; req_bus = bus; req_devfn = devfn;
    req_addr = addr; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (rej) begin
      chk(rej_pulse && !beat_valid, "R9 R10 reject pulse, no beat",
          66'({rej_pulse, beat_valid}), 66'(2'b10));
      @(posedge clk);
      @(negedge clk);
      chk(!rej_pulse && !beat_valid && req_ready, "R10 single-cycle pulse",
          66'({rej_pulse, beat_valid, req_ready}), 66'(3'b001));
    end else begin
      chk(!rej_pulse && beat_valid && !req_ready, "R1 first beat next cycle",
          66'({rej_pulse, beat_valid, req_ready}), 66'(3'b010));
      idx = 0;
      guard = 0;
      while (idx < n && guard < 2000) begin
        beat_ready = (int'($urandom % 100) >= bp);
        #0.5;
        if (beat_valid && beat_ready) begin
          chk({beat_sop, beat_eop, beat_data} == exp[idx],
              idx == 0 ? "R2 R3 R4 beat one" : (n == 3 ? "R5 R8 three-beat write" : "R5 R6 R7 final beat"),
              {beat_sop, beat_eop, beat_data}, exp[idx]);
          idx++;
        end else begin
          chk(beat_valid == 1'b1, "R1 beat held under back-pressure", 66'(beat_valid), 66'(1));
        end
        @(posedge clk);
        @(negedge clk);
        guard++;
      end
      beat_ready = 1'b0;
      chk(!beat_valid && req_ready, "R7 R8 packet length", 66'({beat_valid, req_ready}), 66'(2'b01));
      if (wr && !remote && ofs == 12'h018) m_root = dd[7:0];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !beat_valid && !rej_pulse, "R1 reset state",
        66'({req_ready, beat_valid, rej_pulse}), 66'(3'b100));
    rst_n = 1'b1;

    // R11: reset root is 0, so bus 0 is type 0
    run_req(1'b0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0, 0);
    run_req(1'b0, 8'h03, 8'h09, 12'h0A7, 2'd0, 32'h0, 0);
    run_req(1'b1, 8'h00, 8'h00, 12'h040, 2'd2, 32'hDEAD_BEEF, 30);
    run_req(1'b1, 8'h00, 8'h01, 12'h046, 2'd1, 32'h1234_5678, 30);
    run_req(1'b1, 8'h07, 8'h00, 12'h0FF, 2'd0, 32'h0000_00A5, 50);
    run_req(1'b1, 8'h07, 8'h00, 12'h0F3, 2'd1, 32'h0000_CAFE, 0);
    // R9 hidden base register
    run_req(1'b0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0, 0);
    run_req(1'b1, 8'h00, 8'h00, 12'h012, 2'd1, 32'hFFFF, 0);
    // R10 device above 0 on root and on the bus below
    run_req(1'b0, 8'h00, 8'h08, 12'h000, 2'd2, 32'h0, 0);
    run_req(1'b1, 8'h01, 8'h10, 12'h004, 2'd2, 32'h1, 0);
    run_req(1'b0, 8'h02, 8'h10, 12'h004, 2'd2, 32'h0, 0);
    // R11 root bus change and its effect
    run_req(1'b1, 8'h00, 8'h00, 12'h018, 2'd2, 32'h0003_0205, 20);
    run_req(1'b0, 8'h05, 8'h00, 12'h000, 2'd2, 32'h0, 0);
    run_req(1'b0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0, 0);
    run_req(1'b0, 8'h06, 8'h18, 12'h000, 2'd2, 32'h0, 0);
    run_req(1'b1, 8'h05, 8'h08, 12'h018, 2'd2, 32'h0000_0011, 0);
    run_req(1'b0, 8'h05, 8'h00, 12'h008, 2'd2, 32'h0, 0);

    for (int i = 0; i < 400; i++) begin
      logic [7:0]  bus;
      logic [7:0]  devfn;
      logic [11:0] addr;
      int          r = int'($urandom % 4);
      bus = (r == 0) ? m_root : (r == 1) ? 8'(m_root + 8'd1) : 8'($urandom);
      devfn = ($urandom % 3 == 0) ? 8'($urandom) : {5'd0, 3'($urandom)};
      r = int'($urandom % 6);
      addr = (r == 0) ? (12'h010 | 12'($urandom % 4)) :
             (r == 1) ? (12'h018 | 12'($urandom % 4)) : 12'($urandom);
      run_req(1'($urandom), bus, devfn, addr, 2'($urandom), $urandom, int'($urandom % 60));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule